// File: doc/BRIEF.md
# Wake-up Event Status Controller

This block gathers wake-up requests from five sources into one sticky event register that software reads and clears over a simple synchronous register bus. The sources are two Ethernet magic-packet detectors (single-cycle pulses), a compare match between the count and the reference of a 16-bit timer unit, and two external interrupt pins. Each source has a mask bit. A source can set its event bit only while that mask bit is set.

A single routing control bit chooses where qualified wake events go. When it is clear, they set a summary interrupt bit that can interrupt the processor. When it is set, they drive an external power-management-event (PME) output. The summary bit also records two other conditions. One is a mismatch between the current and the requested power state, which counts only while the state-compare control bit is enabled. The other is a new bus request that arrives while the platform is in low power. The processor interrupt follows the summary bit only when the summary-interrupt enable is set.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After an active-low reset, the event register (address 0), the mask register (address 1) and the control register (address 2) read 0, and `pme_out` and `cpu_irq` are low.
- R2: A one-cycle pulse on `eth_wake[0]` or `eth_wake[1]` sets event bit 26 or bit 27 at the next clock edge, but only when mask bit 26 or 27 is set. With the mask bit clear, the event bit stays 0.
- R3: Writing 1 to an event bit, including summary bit 31, clears it. Writing 0 leaves it unchanged.
- R4: When `tmr_count` equals `tmr_ref` and mask bit 28 is set, event bit 28 is set at the next clock edge.
- R5: `irq_pin[0]` and `irq_pin[1]` (active high by default) pass through a two-flop synchronizer. They set event bits 29 and 30 on the third clock edge after the pin goes active. Detection is level-based, so a bit cleared while its pin is still active sets again.
- R6: When a source sets an event bit in the same cycle that a write-1 clears it, the bit ends up set.
- R7: With control bit 0 (PME routing) set, `pme_out` is high while any of event bits 26 to 30 is set, and wake events do not set bit 31.
- R8: With control bit 0 clear, a qualified wake event sets summary bit 31 in the same cycle as its own bit, and `pme_out` stays low.
- R9: When control bit 1 (state compare) is set and `cur_pstate` differs from `next_pstate`, bit 31 is set. When control bit 1 is clear, a state mismatch has no effect.
- R10: A rising edge on `bus_req` while `low_power` is high sets bit 31. The same edge while `low_power` is low has no effect.
- R11: `cpu_irq` is high exactly when bit 31 is set and mask bit 31 (summary interrupt enable) is set.
- R12: Only mask bits 26 to 31 and control bits 0 and 1 are stored. All other bits of those registers, and any other address, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (2) | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| eth_wake | input | 2 | Magic-packet detect pulses, ports 1 and 2 |
| tmr_count | input | TMR_W (16) | Current count of the timer unit |
| tmr_ref | input | TMR_W (16) | Reference value of the timer unit |
| irq_pin | input | 2 | External interrupt pins 1 and 2 (asynchronous) |
| cur_pstate | input | PSTATE_W (2) | Current power state |
| next_pstate | input | PSTATE_W (2) | Requested next power state |
| low_power | input | 1 | Platform is in low-power mode |
| bus_req | input | 1 | Bus request |
| pme_out | output | 1 | External power-management event |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The main sweep fires each of the five sources in turn. It covers every combination of that source's mask bit and the routing bit, so masking, bit position and routing are told apart for each source. Further patterns check each remaining behaviour on its own. Write-0 against write-1 shows that clears affect only the bits written as 1. A clear in the same cycle as a set shows which one wins. Holding an interrupt pin active shows that detection is by level. State mismatch is tried with the compare bit on and off, and a bus request with low power on and off, so the two summary conditions are separated from their qualifiers. The summary enable is toggled while bit 31 is held, to isolate interrupt gating.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
  localparam int DW        = 32;
  localparam int NSRC      = 5;
  localparam int EVT_LSB   = 26;
  localparam int SUM_BIT   = 31;
  localparam int ADDR_EVT  = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_CTRL = 2;
  localparam int CTL_PME   = 0;
  localparam int CTL_USE   = 1;
  localparam logic [DW-1:0] MASK_BITS = 32'hFC00_0000;
  localparam logic [DW-1:0] CTRL_BITS = 32'h0000_0003;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/wake_src_detect.sv
module wake_src_detect
  import wake_evt_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int PSTATE_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          eth_wake,
  input  logic [TMR_W-1:0]    tmr_count,
  input  logic [TMR_W-1:0]    tmr_ref,
  input  logic [1:0]          irq_lvl,
  input  logic [PSTATE_W-1:0] cur_pstate,
  input  logic [PSTATE_W-1:0] next_pstate,
  input  logic                use_state,
  input  logic                low_power,
  input  logic                bus_req,
  output logic [NSRC-1:0]     src_hit,
  output logic                state_mismatch,
  output logic                bus_wake
);
  logic bus_req_q;
  logic bus_req_d;

  always_comb begin
    src_hit        = {irq_lvl[1], irq_lvl[0], (tmr_count == tmr_ref), eth_wake[1], eth_wake[0]};
    state_mismatch = use_state && (cur_pstate != next_pstate);
    bus_wake       = low_power && bus_req && !bus_req_q;
    bus_req_d      = bus_req;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_req_q <= 1'b0;
    else        bus_req_q <= bus_req_d;
endmodule

// File: rtl/wake_evt_reg.sv
module wake_evt_reg
  import wake_evt_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src_hit,
  input  logic            state_mismatch,
  input  logic            bus_wake,
  output logic [DW-1:0]   ev_q,
  output logic [DW-1:0]   mask_q,
  output logic [DW-1:0]   ctrl_q,
  output logic [DW-1:0]   rdata,
  output logic            pme_out,
  output logic            cpu_irq
);
  logic [DW-1:0]   ev_d, mask_d, ctrl_d, set_v, clr_v;
  logic            ev_en, mask_en, ctrl_en;
  logic [NSRC-1:0] qual;
  logic            pme_en;

  assign pme_en = ctrl_q[CTL_PME];

  always_comb begin
    qual           = src_hit & mask_q[EVT_LSB +: NSRC];
    set_v          = '0;
    set_v[EVT_LSB +: NSRC] = qual;
    set_v[SUM_BIT] = ((|qual) && !pme_en) || state_mismatch || bus_wake;
    clr_v          = (wr_en && addr == AW'(ADDR_EVT)) ? wdata : '0;
    ev_en          = (|set_v) || (|clr_v);
    ev_d           = set_v | (ev_q & ~clr_v);
    mask_en        = wr_en && addr == AW'(ADDR_MASK);
    mask_d         = wdata & MASK_BITS;
    ctrl_en        = wr_en && addr == AW'(ADDR_CTRL);
    ctrl_d         = wdata & CTRL_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (ev_en)   ev_q   <= ev_d;
      if (mask_en) mask_q <= mask_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    unique case (addr)
      AW'(ADDR_EVT):  rdata = ev_q;
      AW'(ADDR_MASK): rdata = mask_q;
      AW'(ADDR_CTRL): rdata = ctrl_q;
      default:        rdata = '0;
    endcase
    pme_out = pme_en && (|ev_q[EVT_LSB +: NSRC]);
    cpu_irq = mask_q[SUM_BIT] && ev_q[SUM_BIT];
  end
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_evt_pkg::*;
#(
  parameter int AW          = 2,
  parameter int TMR_W       = 16,
  parameter int PSTATE_W    = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit IRQ_ACT_LOW = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [1:0]          eth_wake,
  input  logic [TMR_W-1:0]    tmr_count,
  input  logic [TMR_W-1:0]    tmr_ref,
  input  logic [1:0]          irq_pin,
  input  logic [PSTATE_W-1:0] cur_pstate,
  input  logic [PSTATE_W-1:0] next_pstate,
  input  logic                low_power,
  input  logic                bus_req,
  output logic                pme_out,
  output logic                cpu_irq
);
  logic [1:0]      irq_raw, irq_lvl;
  logic [NSRC-1:0] src_hit;
  logic            state_mismatch, bus_wake;
  logic [DW-1:0]   ev_q, mask_q, ctrl_q;

  assign irq_raw = irq_pin ^ {2{IRQ_ACT_LOW}};

  wake_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_raw), .dout(irq_lvl)
  );

  wake_src_detect #(.TMR_W(TMR_W), .PSTATE_W(PSTATE_W)) i_det (
    .clk(clk), .rst_n(rst_n), .eth_wake(eth_wake), .tmr_count(tmr_count),
    .tmr_ref(tmr_ref), .irq_lvl(irq_lvl), .cur_pstate(cur_pstate),
    .next_pstate(next_pstate), .use_state(ctrl_q[CTL_USE]),
    .low_power(low_power), .bus_req(bus_req), .src_hit(src_hit),
    .state_mismatch(state_mismatch), .bus_wake(bus_wake)
  );

  wake_evt_reg #(.AW(AW)) i_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .src_hit(src_hit), .state_mismatch(state_mismatch), .bus_wake(bus_wake),
    .ev_q(ev_q), .mask_q(mask_q), .ctrl_q(ctrl_q), .rdata(rdata),
    .pme_out(pme_out), .cpu_irq(cpu_irq)
  );
endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk #(
  parameter int AW       = 2,
  parameter int PSTATE_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic [31:0]         wdata,
  input logic [31:0]         ev_q,
  input logic [31:0]         mask_q,
  input logic [31:0]         ctrl_q,
  input logic [PSTATE_W-1:0] cur_pstate,
  input logic [PSTATE_W-1:0] next_pstate,
  input logic                pme_out,
  input logic                cpu_irq
);
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[26] && !ev_q[26]) |=> !ev_q[26]);

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wdata[27] && !mask_q[27]) |=> !ev_q[27]);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[31] && !(wr_en && addr == '0 && wdata[31])) |=> ev_q[31]);

  p_pme_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pme_out |-> ctrl_q[0]);

  p_mismatch_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && cur_pstate != next_pstate) |=> ev_q[31]);

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> mask_q[31]);
endmodule

bind wake_evt_ctrl wake_evt_chk #(.AW(AW), .PSTATE_W(PSTATE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ev_q(ev_q), .mask_q(mask_q), .ctrl_q(ctrl_q), .cur_pstate(cur_pstate),
  .next_pstate(next_pstate), .pme_out(pme_out), .cpu_irq(cpu_irq)
);

// File: tb/test_wake_evt_ctrl.sv
`timescale 1ns/1ps
module test_wake_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, low_power, bus_req, pme_out, cpu_irq;
  logic [1:0]  addr, eth_wake, irq_pin, cur_pstate, next_pstate;
  logic [31:0] wdata, rdata, rv;
  logic [15:0] tmr_count, tmr_ref;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wake_evt_ctrl i_wake_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eth_wake(eth_wake), .tmr_count(tmr_count),
    .tmr_ref(tmr_ref), .irq_pin(irq_pin), .cur_pstate(cur_pstate),
    .next_pstate(next_pstate), .low_power(low_power), .bus_req(bus_req),
    .pme_out(pme_out), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk);
    case (s)
      0, 1:    eth_wake[s] = 1'b1;
      2:       tmr_count = tmr_ref;
      default: irq_pin[s-3] = 1'b1;
    endcase
    @(negedge clk);
    eth_wake = '0; irq_pin = '0; tmr_count = tmr_ref + 16'd1;
    step(5);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; eth_wake = '0;
    irq_pin = '0; cur_pstate = '0; next_pstate = '0; low_power = 1'b0;
    bus_req = 1'b0; tmr_ref = 16'h1234; tmr_count = 16'h0000;
    step(3); rst_n = 1'b1; step(1);

    // R1 reset state
    rd(2'd0, rv); chk("R1 event", rv, 32'h0);
    rd(2'd1, rv); chk("R1 mask", rv, 32'h0);
    rd(2'd2, rv); chk("R1 control", rv, 32'h0);
    chk("R1 outputs", {30'd0, pme_out, cpu_irq}, 32'h0);

    // R2 R4 R5 R7 R8: every source x mask x routing
    for (int s = 0; s < 5; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] exp;
          string tag;
          tag = (s < 2) ? "R2" : (s == 2) ? "R4" : "R5";
          wr(2'd1, (32'(m) << (26 + s)) | 32'h8000_0000);
          wr(2'd2, 32'(p));
          wr(2'd0, 32'hFFFF_FFFF);
          pulse_src(s);
          exp = (m == 1) ? ((32'h1 << (26 + s)) | ((p == 0) ? 32'h8000_0000 : 32'h0)) : 32'h0;
          rd(2'd0, rv);
          chk($sformatf("%s src%0d m%0d p%0d event", tag, s, m, p), rv, exp);
          chk($sformatf("R7 src%0d m%0d p%0d pme_out", s, m, p), {31'd0, pme_out}, 32'(m & p));
          chk($sformatf("R8 R11 src%0d m%0d p%0d cpu_irq", s, m, p), {31'd0, cpu_irq}, 32'(m & (1 - p)));
          wr(2'd0, 32'hFFFF_FFFF);
          rd(2'd0, rv);
          chk($sformatf("R3 src%0d clear", s), rv, 32'h0);
        end
      end
    end

    // R3 write 0 keeps, write 1 to bit 31 clears only bit 31
    wr(2'd1, 32'h0400_0000); wr(2'd2, 32'h0);
    pulse_src(0);
    wr(2'd0, 32'h0);
    rd(2'd0, rv); chk("R3 write0 keeps", rv, 32'h8400_0000);
    wr(2'd0, 32'h8000_0000);
    rd(2'd0, rv); chk("R3 clear summary only", rv, 32'h0400_0000);
    wr(2'd0, 32'hFFFF_FFFF);

    // R6 set wins over simultaneous clear
    wr(2'd2, 32'h1);
    @(negedge clk); eth_wake[0] = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 32'h0400_0000;
    @(negedge clk); eth_wake[0] = 1'b0; wr_en = 1'b0; wdata = '0;
    rd(2'd0, rv); chk("R6 set wins", rv, 32'h0400_0000);
    wr(2'd0, 32'hFFFF_FFFF);

    // R5 level detection re-sets after clear
    wr(2'd1, 32'h2000_0000);
    @(negedge clk); irq_pin[0] = 1'b1;
    step(4);
    wr(2'd0, 32'h2000_0000);
    rd(2'd0, rv); chk("R5 level re-set", rv, 32'h2000_0000);
    irq_pin[0] = 1'b0; step(4);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rv); chk("R5 released clears", rv, 32'h0);

    // R9 state mismatch
    cur_pstate = 2'd1; next_pstate = 2'd2;
    wr(2'd2, 32'h0);
    step(2);
    rd(2'd0, rv); chk("R9 compare off", rv, 32'h0);
    wr(2'd2, 32'h2);
    step(1);
    rd(2'd0, rv); chk("R9 mismatch", rv, 32'h8000_0000);
    next_pstate = 2'd1;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rv); chk("R9 match", rv, 32'h0);
    wr(2'd2, 32'h0);

    // R10 bus request during low power
    @(negedge clk); bus_req = 1'b1; @(negedge clk); bus_req = 1'b0; step(1);
    rd(2'd0, rv); chk("R10 not low power", rv, 32'h0);
    low_power = 1'b1;
    @(negedge clk); bus_req = 1'b1; @(negedge clk); bus_req = 1'b0; step(1);
    rd(2'd0, rv); chk("R10 low power", rv, 32'h8000_0000);

    // R11 summary enable gating
    wr(2'd1, 32'h0);
    chk("R11 enable off", {31'd0, cpu_irq}, 32'h0);
    wr(2'd1, 32'h8000_0000);
    chk("R11 enable on", {31'd0, cpu_irq}, 32'h1);
    low_power = 1'b0;
    wr(2'd0, 32'hFFFF_FFFF);

    // R12 stored bits and unused address
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, rv); chk("R12 mask bits", rv, 32'hFC00_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, rv); chk("R12 control bits", rv, 32'h0000_0003);
    rd(2'd3, rv); chk("R12 unused address", rv, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule